// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven management-bus master. Software writes a 16-bit value into a data register when a write is wanted. It then writes a command word that holds a PHY address, a register address, a clock divider threshold and one start bit. The controller then runs one clause-22 frame on the two-wire management bus. It generates the management clock, drives the data line through an output enable, and releases the line for the turnaround and data phase of a read.

The start bit that launched the frame reads back as 1 while the frame runs. Hardware clears it when the last bit time ends, so software polls that bit to learn that the frame is finished. After a read, the 16 bits that the PHY returned are held in the upper half of the data register. The clock divider threshold sets each half-period of the management clock in system clocks. A command written while a frame is running is dropped.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0x0000D000 (threshold 0x34, both addresses 0, both start bits 0), the data register reads 0, and MDC and the MDIO output enable are low.
- R2: Command register layout: PHY address in bits 4:0, register address in bits 9:5, threshold in bits 17:10, read start in bit 26 and write start in bit 27. A start bit that began a frame reads 1 until the frame ends and reads 0 from the cycle after its last bit time.
- R3: While a frame runs, MDC is high for exactly threshold system clocks in each bit time and low for the same count, so the period is twice the threshold. A threshold of 0 behaves as 1. While idle, MDC and the output enable stay low.
- R4: Each frame is 64 bit times, MSB first: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, turnaround, then 16 data bits. A write drives turnaround 10.
- R5: For a read, the master releases MDIO from bit time 46 through bit time 63. It samples the 16 data bits on the rising MDC edges of bit times 48 to 63, and they appear in data register bits 31:16 once the start bit has cleared.
- R6: A write transmits data register bits 15:0 as they stood when the command was written.
- R7: A command register write while a frame runs is ignored. The stored fields, the start bits and the frame on the wire are unchanged.
- R8: When a command word sets both start bits, a read is performed, and only bit 26 reads back as set.
- R9: The start bit clears exactly 128 × threshold system clocks after the clock edge that accepted the command.
- R10: A write frame leaves the read-data field (bits 31:16) of the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read value of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
On every cycle the assertions check several properties. The start bits are mutually exclusive and track the frame engine's busy state, and they clear right after the final bit. The stored command fields cannot move while a frame is running. The data line and its enable change only on falling MDC edges, and both the clock and the enable are quiet while idle. The exact bit pattern on the wire, the returned read value, the half-period length for each threshold including zero, and the total frame duration can only be shown by the bench's scenarios, which decode the frame with a responder PHY.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

   localparam int ADDR_W    = 5;
   localparam int DATA_W    = 16;
   localparam int THR_W     = 8;
   localparam int PHY_LSB   = 0;
   localparam int REGA_LSB  = 5;
   localparam int THR_LSB   = 10;
   localparam int RD_BIT    = 26;
   localparam int WR_BIT    = 27;
   localparam int WDATA_LSB = 0;
   localparam int RDATA_LSB = 16;

   typedef enum logic {
      SEL_CMD  = 1'b0,
      SEL_DATA = 1'b1
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } mdio_op_e;

   typedef struct packed {
      logic              rd;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
   } cmd_t;

endpackage

// File: rtl/mdio_cmd_clkgen.sv
module mdio_cmd_clkgen #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [THR_W-1:0] thr,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);

   logic [THR_W-1:0] cnt;
   logic [THR_W-1:0] thr_eff;
   logic             hit;

   always_comb begin
      thr_eff = (thr == '0) ? THR_W'(1) : thr;
      hit     = run && (cnt == thr_eff - THR_W'(1));
      rise    = hit && !mdc;
      fall    = hit && mdc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (hit) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + THR_W'(1);
      end
   end

endmodule

// File: rtl/mdio_cmd_frame.sv
module mdio_cmd_frame
   import mdio_cmd_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cmd_t              cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_in,
   output logic              busy,
   output logic              done,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rx_data
);

   localparam int FRAME_BITS = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int TA_IDX     = PRE_LEN + 4 + 2 * ADDR_W;
   localparam int DAT_IDX    = TA_IDX + 2;
   localparam int LAST_IDX   = FRAME_BITS - 1;

   logic [FRAME_BITS-1:0] tx_sh;
   logic [IDX_W-1:0]      idx;
   logic                  rd_op;
   logic                  at_last;
   logic                  in_release;
   logic                  in_data;
   mdio_op_e              op;

   always_comb begin
      op         = cmd.rd ? OP_READ : OP_WRITE;
      at_last    = (idx == IDX_W'(LAST_IDX));
      in_release = rd_op && (idx >= IDX_W'(TA_IDX));
      in_data    = rd_op && (idx >= IDX_W'(DAT_IDX));
      done       = busy && fall && at_last;
      mdio_o     = tx_sh[FRAME_BITS-1];
      mdio_oe    = busy && !in_release;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         rd_op   <= 1'b0;
         tx_sh   <= '1;
         rx_data <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         idx   <= '0;
         rd_op <= cmd.rd;
         tx_sh <= {{PRE_LEN{1'b1}}, 2'b01, op, cmd.phy, cmd.regad, 2'b10,
                   (cmd.rd ? {DATA_W{1'b1}} : wdata)};
      end else if (busy) begin
         if (rise && in_data) begin
            rx_data <= {rx_data[DATA_W-2:0], mdio_in};
         end
         if (fall) begin
            if (at_last) begin
               busy  <= 1'b0;
               idx   <= '0;
               tx_sh <= '1;
            end else begin
               idx   <= idx + IDX_W'(1);
               tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b1};
            end
         end
      end
   end

   AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mdio_oe)) |-> $past(fall)) // R5
      else $error("output enable moved away from a falling MDC edge");

   AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall)) // R4
      else $error("driven bit moved away from a falling MDC edge");

   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy) // R9
      else $error("frame still busy after its final bit");

endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
   import mdio_cmd_pkg::*;
#(
   parameter int             REG_W   = 32,
   parameter logic [THR_W-1:0] DEF_THR = 8'h34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_data,
   output logic              start,
   output cmd_t              start_cmd,
   output logic [THR_W-1:0]  thr,
   output logic [DATA_W-1:0] wdata,
   output logic              go_any
);

   logic [ADDR_W-1:0] phy_q;
   logic [ADDR_W-1:0] rega_q;
   logic              rd_go;
   logic              wr_go;
   logic [DATA_W-1:0] rdata_q;
   logic              cmd_wr;
   logic              data_wr;
   logic              w_rd;
   logic              w_wr;

   always_comb begin
      go_any          = rd_go | wr_go;
      cmd_wr          = reg_wr && (reg_sel == SEL_CMD) && !go_any;
      data_wr         = reg_wr && (reg_sel == SEL_DATA);
      w_rd            = reg_wdata[RD_BIT];
      w_wr            = reg_wdata[WR_BIT] && !w_rd;
      start           = cmd_wr && (w_rd || w_wr);
      start_cmd.rd    = w_rd;
      start_cmd.phy   = reg_wdata[PHY_LSB +: ADDR_W];
      start_cmd.regad = reg_wdata[REGA_LSB +: ADDR_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phy_q   <= '0;
         rega_q  <= '0;
         thr     <= DEF_THR;
         rd_go   <= 1'b0;
         wr_go   <= 1'b0;
         wdata   <= '0;
         rdata_q <= '0;
      end else begin
         if (cmd_wr) begin
            phy_q  <= reg_wdata[PHY_LSB +: ADDR_W];
            rega_q <= reg_wdata[REGA_LSB +: ADDR_W];
            thr    <= reg_wdata[THR_LSB +: THR_W];
            rd_go  <= w_rd;
            wr_go  <= w_wr;
         end else if (done) begin
            rd_go <= 1'b0;
            wr_go <= 1'b0;
         end
         if (done && rd_go) begin
            rdata_q <= rx_data;
         end
         if (data_wr) begin
            wdata <= reg_wdata[WDATA_LSB +: DATA_W];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel == SEL_DATA) begin
         reg_rdata[WDATA_LSB +: DATA_W] = wdata;
         reg_rdata[RDATA_LSB +: DATA_W] = rdata_q;
      end else begin
         reg_rdata[PHY_LSB +: ADDR_W]  = phy_q;
         reg_rdata[REGA_LSB +: ADDR_W] = rega_q;
         reg_rdata[THR_LSB +: THR_W]   = thr;
         reg_rdata[RD_BIT]             = rd_go;
         reg_rdata[WR_BIT]             = wr_go;
      end
   end

   AST_ONE_GO: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_go, wr_go})) // R8
      else $error("read and write start bits both set");

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(go_any) && go_any) |-> ($stable(phy_q) && $stable(rega_q) && $stable(thr))) // R7
      else $error("command fields moved during a frame");

   AST_GO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !(rd_go || wr_go)) // R2
      else $error("start bit not cleared at frame end");

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_cmd_pkg::*;
#(
   parameter int               REG_W       = 32,
   parameter int               PRE_LEN     = 32,
   parameter int               SYNC_STAGES = 0,
   parameter logic [THR_W-1:0] DEF_THR     = 8'h34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);

   if (REG_W < WR_BIT + 1) begin : g_bad_regw
      $error("REG_W too narrow for the command layout");
   end
   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN out of range");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES out of range");
   end
   if (DEF_THR == '0) begin : g_bad_thr
      $error("DEF_THR must be non-zero");
   end

   logic              start;
   cmd_t              start_cmd;
   logic [THR_W-1:0]  thr;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rx_data;
   logic              go_any;
   logic              busy;
   logic              done;
   logic              rise;
   logic              fall;
   logic              mdio_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign mdio_s = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q, mdio_i}[SYNC_STAGES-1:0];
      end
      assign mdio_s = sync_q[SYNC_STAGES-1];
   end

   mdio_cmd_regs #(
      .REG_W   (REG_W),
      .DEF_THR (DEF_THR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .done      (done),
      .rx_data   (rx_data),
      .start     (start),
      .start_cmd (start_cmd),
      .thr       (thr),
      .wdata     (wdata),
      .go_any    (go_any)
   );

   mdio_cmd_clkgen #(
      .THR_W (THR_W)
   ) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .thr   (thr),
      .mdc   (mdc),
      .rise  (rise),
      .fall  (fall)
   );

   mdio_cmd_frame #(
      .PRE_LEN (PRE_LEN)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cmd     (start_cmd),
      .wdata   (wdata),
      .rise    (rise),
      .fall    (fall),
      .mdio_in (mdio_s),
      .busy    (busy),
      .done    (done),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .rx_data (rx_data)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe)) // R3
      else $error("bus active while idle");

   AST_GO_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      go_any == busy) // R2
      else $error("start bit disagrees with frame state");

endmodule

// File: tb/mdio_cmd_ctrl_test.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   mdio_cmd_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // responder PHY
   logic        phy_clr = 1'b0;
   logic [63:0] cap, oeh;
   int          rc = 0;
   logic        is_rd = 1'b0;
   logic [15:0] rdv = '0;
   logic        phy_en = 1'b0;
   logic        phy_val = 1'b1;
   logic        line;

   function automatic logic [15:0] phy_value(input logic [4:0] p, input logic [4:0] r);
      return {3'b101, p, r, ~p[2:0]};
   endfunction

   assign line   = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);
   assign mdio_i = line;

   always @(posedge mdc or posedge phy_clr) begin
      if (phy_clr) begin
         rc <= 0; cap <= '0; oeh <= '0;
      end else begin
         cap <= {cap[62:0], line};
         oeh <= {oeh[62:0], mdio_oe};
         rc  <= rc + 1;
      end
   end

   always @(negedge mdc or posedge phy_clr) begin
      if (phy_clr) begin
         phy_en <= 1'b0; is_rd <= 1'b0;
      end else begin
         if (rc == 46) begin
            is_rd <= (cap[11:10] == 2'b10);
            rdv   <= phy_value(cap[9:5], cap[4:0]);
         end
         if (is_rd && rc >= 47 && rc <= 63) begin
            phy_en  <= 1'b1;
            phy_val <= (rc == 47) ? 1'b0 : rdv[63-rc];
         end else begin
            phy_en <= 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10,
              (rd ? phy_value(p, r) : d)};
   endfunction

   logic [15:0] last_rd = '0;

   task automatic reg_write(input logic sel, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic run_cmd(input bit rd, input bit wr, input logic [4:0] p, input logic [4:0] r,
                          input logic [7:0] thr, input logic [15:0] d, input bit poke);
      logic [31:0] cmdw;
      int thr_e, cnt, hi;
      bit eff_rd;
      eff_rd = rd;
      thr_e  = (thr == 0) ? 1 : int'(thr);
      reg_write(1'b1, {16'h0, d});
      phy_clr = 1'b1; #1 phy_clr = 1'b0;
      cmdw = (32'(rd) << 26) | (32'(wr) << 27) | (32'(thr) << 10) | (32'(r) << 5) | 32'(p);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = cmdw;
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
      chk(reg_rdata[26] == eff_rd && reg_rdata[27] == (!eff_rd && wr), "R2/R8 start bits while busy",
          64'(reg_rdata[27:26]), 64'({!eff_rd && wr, eff_rd}));
      cnt = 0; hi = 0;
      while (cnt < 40000) begin
         @(negedge clk);
         cnt++;
         if (mdc) hi++;
         if (poke && cnt == 3) begin
            reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ~cmdw;
         end
         if (poke && cnt == 4) reg_wr = 1'b0;
         #1;
         if (!reg_rdata[26] && !reg_rdata[27]) break;
      end
      chk(cnt == 128 * thr_e, "R9 completion time", 64'(cnt), 64'(128 * thr_e));
      chk(hi == 64 * thr_e, "R3 MDC high time", 64'(hi), 64'(64 * thr_e));
      chk(cap == exp_frame(eff_rd, p, r, d), "R4/R6 frame on wire", cap, exp_frame(eff_rd, p, r, d));
      chk(oeh == (eff_rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF), "R5 output enable per bit",
          oeh, (eff_rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF));
      chk(reg_rdata == ((32'(thr) << 10) | (32'(r) << 5) | 32'(p)), "R2/R7 command readback after frame",
          64'(reg_rdata), 64'((32'(thr) << 10) | (32'(r) << 5) | 32'(p)));
      if (eff_rd) last_rd = phy_value(p, r);
      reg_sel = 1'b1; #1;
      chk(reg_rdata == {last_rd, d}, eff_rd ? "R5 read data field" : "R10 read field kept after write",
          64'(reg_rdata), 64'({last_rd, d}));
      reg_sel = 1'b0;
      chk(!mdc && !mdio_oe, "R3 bus idle after frame", 64'({mdc, mdio_oe}), 64'h0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hang expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h1d5a);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(reg_rdata == 32'h0000_D000, "R1 command reset value", 64'(reg_rdata), 64'h0000_D000);
      chk(!mdc && !mdio_oe, "R1 bus idle at reset", 64'({mdc, mdio_oe}), 64'h0);
      reg_sel = 1'b1; #1;
      chk(reg_rdata == 32'h0, "R1 data reset value", 64'(reg_rdata), 64'h0);
      reg_sel = 1'b0;

      // directed corners
      run_cmd(1'b1, 1'b0, 5'h01, 5'h02, 8'h34, 16'h0000, 1'b0); // default divider, read
      run_cmd(1'b0, 1'b1, 5'h1F, 5'h00, 8'h00, 16'hA5C3, 1'b0); // zero threshold, write (R3, R10)
      run_cmd(1'b1, 1'b1, 5'h0A, 5'h15, 8'h02, 16'h1234, 1'b0); // both bits: read wins (R8)
      run_cmd(1'b0, 1'b1, 5'h11, 5'h0C, 8'h03, 16'h8001, 1'b1); // command during frame ignored (R7)
      run_cmd(1'b1, 1'b0, 5'h04, 5'h1E, 8'h01, 16'hFFFF, 1'b1);

      // random mix
      for (int i = 0; i < 10; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         run_cmd(rv[0], rv[1] | ~rv[0], rv[6:2], rv[11:7], 8'(rv[14:12]),
                 rv[31:16], rv[15]);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule